// File: doc/BRIEF.md
# Programmable Address Latch with Column Increment

This block holds the row, column and bank parts of a memory address for a video DRAM controller. A configuration input chooses between two behaviours: a permanent pass-through, in which the address outputs simply mirror the address inputs, and a latching behaviour, in which a strobe opens and closes the latch. Two strobe conventions are selectable. One uses an active-high address-latch-enable that keeps the latch open while it is high. The other uses an address strobe that closes the latch while it is asserted.

Once the address is held, a column-step input advances the column field by one on every rising clock edge. The column wraps to zero after its all-ones value, and the row and bank fields stay fixed. This supports back-to-back accesses within one row. While the refresh engine reports that a refresh is running, the column-step input is given a second meaning. It then leaves the column alone and raises a refresh-extend output instead. Refresh timing and strobe generation for the memory belong to other blocks.

Top module: `addr_latch_colinc`

## Requirements
- R1: With `latch_en` low (pass-through), `row_out`, `col_out` and `bank_out` equal `row_in`, `col_in` and `bank_in` in the same cycle, whatever the strobes and `col_inc` do.
- R2: With `latch_en` high and `strobe_mode` = 0, the outputs follow the inputs while `ale` is high. While `ale` is low, they show the address sampled at the last rising clock edge at which `ale` was high. `ads` has no effect in this mode.
- R3: With `latch_en` high and `strobe_mode` = 1, the outputs follow the inputs while `ads` is low. While `ads` is high (asserted), they show the address sampled at the last rising clock edge before `ads` was seen high. `ale` has no effect in this mode.
- R4: While the latch is closed, `col_inc` is high and `refresh_busy` is low, the held column grows by one at each rising clock edge. The new value is visible on `col_out` right after that edge.
- R5: A step taken from the all-ones column value gives column zero.
- R6: `extend_refresh` is high exactly when `col_inc` and `refresh_busy` are both high. In the cycles where both are high, the held column does not change.
- R7: While the latch is closed, the held row and bank never change, including during column steps.
- R8: A synchronous active-low reset clears the held row, column and bank to zero. With the latch closed after reset, all three outputs read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strobe_mode | input | 1 | 0: `ale` convention, 1: `ads` convention |
| latch_en | input | 1 | 1: latching, 0: permanent pass-through |
| ale | input | 1 | Address-latch-enable, latch open while high (mode 0) |
| ads | input | 1 | Address strobe, latch closed while high (mode 1) |
| col_inc | input | 1 | Column step, or refresh-extend request during refresh |
| refresh_busy | input | 1 | High while a refresh is in progress |
| row_in | input | ROW_W | Raw row address |
| col_in | input | COL_W | Raw column address |
| bank_in | input | BANK_W | Raw bank select |
| row_out | output | ROW_W | Row address to the memory address path |
| col_out | output | COL_W | Column address to the memory address path |
| bank_out | output | BANK_W | Bank select to the memory address path |
| extend_refresh | output | 1 | Request to lengthen the running refresh |

## Verification
The bench builds the block with a 4-bit row, a 3-bit column and a 2-bit bank. The narrow column puts the all-ones value only a few steps away from any captured address, so wrap-around and repeated wraps happen many times within a short run. The small row and bank fields let random addresses exercise every bit of the held fields, and a change of a held field is easy to see. A behavioural model runs alongside the block and compares all four outputs on every clock, in both strobe conventions and in pass-through.

// File: rtl/al_pkg.sv
// Package: shared types for the address latch block.
// Assumes: nothing beyond IEEE 1800-2017.
package al_pkg;

    // Strobe convention chosen by the strobe_mode pin.
    typedef enum logic {
        SEL_ALE = 1'b0,   // latch open while ale is high
        SEL_ADS = 1'b1    // latch closed while ads is high
    } strobe_sel_e;

endpackage

// File: rtl/al_gate.sv
// Module: al_gate
// Decides, from the configuration and strobes, whether the latch is open
// (transparent) this cycle, whether the held column may step, and whether
// the step input is being used as a refresh-extend request instead.
// Assumes: all inputs are synchronous to the block clock.
module al_gate
    import al_pkg::*;
(
    input  strobe_sel_e mode,
    input  logic        latch_en,
    input  logic        ale,
    input  logic        ads,
    input  logic        col_inc,
    input  logic        refresh_busy,
    output logic        open,
    output logic        step_col,
    output logic        extend_refresh
);

    logic strobe_open;

    // Purpose: translate the selected strobe convention into "latch open".
    always_comb begin
        unique case (mode)
            SEL_ALE: strobe_open = ale;
            SEL_ADS: strobe_open = ~ads;
            default: strobe_open = 1'b0;
        endcase
    end

    // Purpose: pass-through overrides the strobe; the column steps only while closed.
    always_comb begin
        open           = ~latch_en | strobe_open;
        step_col       = ~open & col_inc & ~refresh_busy;
        extend_refresh = col_inc & refresh_busy;
    end

endmodule

// File: rtl/al_field_reg.sv
// Module: al_field_reg
// Holding register for one address field (row or bank). Loads the raw
// field while the latch is open and keeps its value otherwise.
// Assumes: synchronous active-low reset; load is a clean synchronous level.
module al_field_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Purpose: clear on reset, sample while open, hold while closed.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end

    AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q)); // R7

    AST_FIELD_RESET: assert property (@(posedge clk)
        !rst_n |=> (q == '0)); // R8

endmodule

// File: rtl/al_col_counter.sv
// Module: al_col_counter
// Holding register for the column field with a wrap-around step. A load
// takes priority over a step; stepping from all ones returns to zero.
// Assumes: load and step come from al_gate and are never both high.
module al_col_counter #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    localparam logic [W-1:0] TOP_VAL = {W{1'b1}};
    localparam logic [W-1:0] ONE_VAL = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] q_next_step;

    // Purpose: next column on a step, wrapping from TOP_VAL to zero.
    always_comb begin
        if (q == TOP_VAL) q_next_step = '0;
        else              q_next_step = q + ONE_VAL;
    end

    // Purpose: clear on reset, load while open, step while closed.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
        else if (step) q <= q_next_step;
    end

    AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && q != TOP_VAL) |=> (q == $past(q) + ONE_VAL)); // R4

    AST_COL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && q == TOP_VAL) |=> (q == '0)); // R5

    AST_COL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(q)); // R6

    AST_COL_RESET: assert property (@(posedge clk)
        !rst_n |=> (q == '0)); // R8

endmodule

// File: rtl/addr_latch_colinc.sv
// Module: addr_latch_colinc (top)
// Programmable address latch for a video DRAM controller. Holds row,
// column and bank; in pass-through or while the strobe keeps the latch open,
// the outputs show the raw inputs directly. While closed, col_inc steps the
// held column unless a refresh is running, in which case it raises
// extend_refresh instead.
// Assumes: inputs are synchronous to clk; reset is synchronous, active low.
module addr_latch_colinc
    import al_pkg::*;
#(
    parameter int ROW_W  = 10,
    parameter int COL_W  = 10,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_mode,
    input  logic              latch_en,
    input  logic              ale,
    input  logic              ads,
    input  logic              col_inc,
    input  logic              refresh_busy,
    input  logic [ROW_W-1:0]  row_in,
    input  logic [COL_W-1:0]  col_in,
    input  logic [BANK_W-1:0] bank_in,
    output logic [ROW_W-1:0]  row_out,
    output logic [COL_W-1:0]  col_out,
    output logic [BANK_W-1:0] bank_out,
    output logic              extend_refresh
);

    localparam int ADDR_W = ROW_W + COL_W + BANK_W;

    strobe_sel_e       mode;
    logic              open;
    logic              step_col;
    logic [ROW_W-1:0]  row_held;
    logic [COL_W-1:0]  col_held;
    logic [BANK_W-1:0] bank_held;
    logic [ADDR_W-1:0] raw_bus;
    logic [ADDR_W-1:0] held_bus;
    logic [ADDR_W-1:0] out_bus;

    // Purpose: give the raw mode pin its enumerated meaning.
    always_comb mode = strobe_sel_e'(strobe_mode);

    al_gate u_gate (
        .mode           (mode),
        .latch_en       (latch_en),
        .ale            (ale),
        .ads            (ads),
        .col_inc        (col_inc),
        .refresh_busy   (refresh_busy),
        .open           (open),
        .step_col       (step_col),
        .extend_refresh (extend_refresh)
    );

    al_field_reg #(.W(ROW_W)) u_row (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (open),
        .d     (row_in),
        .q     (row_held)
    );

    al_col_counter #(.W(COL_W)) u_col (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (open),
        .step  (step_col),
        .d     (col_in),
        .q     (col_held)
    );

    al_field_reg #(.W(BANK_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (open),
        .d     (bank_in),
        .q     (bank_held)
    );

    // Purpose: pack raw and held fields into one bus for the output select.
    always_comb begin
        raw_bus  = {bank_in, row_in, col_in};
        held_bus = {bank_held, row_held, col_held};
    end

    // Purpose: per-bit output select; open shows the raw address directly.
    for (genvar b = 0; b < ADDR_W; b++) begin : g_out_sel
        always_comb out_bus[b] = open ? raw_bus[b] : held_bus[b];
    end

    // Purpose: split the selected bus back into the output fields.
    always_comb begin
        col_out  = out_bus[COL_W-1:0];
        row_out  = out_bus[COL_W +: ROW_W];
        bank_out = out_bus[COL_W+ROW_W +: BANK_W];
    end

    AST_PASS_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_en |=> (row_held == $past(row_in) && col_held == $past(col_in)
                       && bank_held == $past(bank_in))); // R1

    AST_ALE_SAMPLES: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_en && !strobe_mode && ale) |=> (col_held == $past(col_in)
                                              && row_held == $past(row_in))); // R2

    AST_ADS_SAMPLES: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_en && strobe_mode && !ads) |=> (col_held == $past(col_in)
                                              && row_held == $past(row_in))); // R3

    AST_REFRESH_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_en && !open && col_inc && refresh_busy) |=> $stable(col_held)); // R6

    AST_EXTEND_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !col_inc |-> !extend_refresh); // R6

endmodule

// File: tb/tb_addr_latch_colinc.sv
module tb_addr_latch_colinc;

    localparam int RW = 4;
    localparam int CW = 3;
    localparam int BW = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          strobe_mode, latch_en, ale, ads, col_inc, refresh_busy;
    logic [RW-1:0] row_in, row_out;
    logic [CW-1:0] col_in, col_out;
    logic [BW-1:0] bank_in, bank_out;
    logic          extend_refresh;

    int    checks = 0;
    int    fails  = 0;
    string phase  = "R8";
    bit    cmp_on = 1'b0;
    bit    done   = 1'b0;
    int    m_row, m_col, m_bank;

    always #10 clk = ~clk;  // 50 MHz

    addr_latch_colinc #(.ROW_W(RW), .COL_W(CW), .BANK_W(BW)) dut (
        .clk(clk), .rst_n(rst_n), .strobe_mode(strobe_mode), .latch_en(latch_en),
        .ale(ale), .ads(ads), .col_inc(col_inc), .refresh_busy(refresh_busy),
        .row_in(row_in), .col_in(col_in), .bank_in(bank_in),
        .row_out(row_out), .col_out(col_out), .bank_out(bank_out),
        .extend_refresh(extend_refresh)
    );

    function automatic bit m_open();
        if (!latch_en) return 1'b1;
        return strobe_mode ? !ads : ale;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    // Reference model: state update on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_row = 0; m_col = 0; m_bank = 0;
        end else if (m_open()) begin
            m_row = row_in; m_col = col_in; m_bank = bank_in;
        end else if (col_inc && !refresh_busy) begin
            m_col = (m_col + 1) % (1 << CW);
        end
        cmp_on <= 1'b1;
    end

    // Compare on every falling edge, away from the active edge.
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            string rq;
            rq = (phase == "R4" || phase == "R5") ? "R7" : phase;
            chk(phase, "col_out", int'(col_out), m_open() ? int'(col_in) : m_col);
            chk(rq, "row_out", int'(row_out), m_open() ? int'(row_in) : m_row);
            chk(rq, "bank_out", int'(bank_out), m_open() ? int'(bank_in) : m_bank);
            chk("R6", "extend_refresh", int'(extend_refresh), int'(col_inc && refresh_busy));
        end
    end

    task automatic go(int n);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic rnd_addr();
        row_in  = RW'($urandom);
        col_in  = CW'($urandom);
        bank_in = BW'($urandom);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=expired expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; strobe_mode = 1'b0; latch_en = 1'b1; ale = 1'b0; ads = 1'b0;
        col_inc = 1'b0; refresh_busy = 1'b0;
        row_in = 4'd9; col_in = 3'd5; bank_in = 2'd3;
        go(3);
        rst_n = 1'b1;
        go(1);
        // R8: closed latch after reset reads zero
        chk("R8", "row after reset", int'(row_out), 0);
        chk("R8", "col after reset", int'(col_out), 0);
        chk("R8", "bank after reset", int'(bank_out), 0);

        // R1: pass-through with strobes and steps wiggling
        phase = "R1"; latch_en = 1'b0;
        for (int i = 0; i < 12; i++) begin
            rnd_addr(); col_inc = i[0]; ale = i[1]; ads = i[2];
            go(1);
        end
        ale = 1'b0; ads = 1'b0; col_inc = 1'b0; latch_en = 1'b1;

        // R2: ale convention, ads ignored
        phase = "R2"; strobe_mode = 1'b0;
        for (int k = 0; k < 4; k++) begin
            ale = 1'b1;
            for (int i = 0; i < 3; i++) begin rnd_addr(); go(1); end
            ale = 1'b0;
            for (int i = 0; i < 5; i++) begin rnd_addr(); ads = i[0]; go(1); end
        end
        ads = 1'b0;

        // R4 then R5: steps and wrap with a known start
        phase = "R4";
        ale = 1'b1; row_in = 4'd10; col_in = 3'd2; bank_in = 2'd1; go(1);
        ale = 1'b0; rnd_addr(); col_inc = 1'b1; go(2);
        chk("R4", "col after two steps", int'(col_out), 4);
        col_inc = 1'b0; go(2);
        phase = "R5";
        ale = 1'b1; col_in = 3'd6; go(1);
        ale = 1'b0; rnd_addr(); col_inc = 1'b1; go(2);
        chk("R5", "col after wrap", int'(col_out), 0);
        go(10);
        col_inc = 1'b0;

        // R6: refresh turns steps into extend requests
        phase = "R6"; refresh_busy = 1'b1;
        for (int i = 0; i < 8; i++) begin col_inc = i[0] | i[1]; go(1); end
        chk("R6", "extend flag", int'(extend_refresh), int'(col_inc));
        refresh_busy = 1'b0; col_inc = 1'b1; go(3);
        col_inc = 1'b0;

        // R3: ads convention, ale ignored
        phase = "R3"; strobe_mode = 1'b1; ads = 1'b0;
        for (int k = 0; k < 4; k++) begin
            ads = 1'b0;
            for (int i = 0; i < 2; i++) begin rnd_addr(); go(1); end
            ads = 1'b1;
            for (int i = 0; i < 6; i++) begin
                rnd_addr(); ale = i[0]; col_inc = i[1]; refresh_busy = (i == 5);
                go(1);
            end
        end
        ale = 1'b0; col_inc = 1'b0; refresh_busy = 1'b0;

        // R7: long step run in ads mode with the raw inputs changing
        phase = "R7";
        ads = 1'b0; rnd_addr(); go(1);
        ads = 1'b1; col_inc = 1'b1;
        for (int i = 0; i < 12; i++) begin rnd_addr(); go(1); end
        col_inc = 1'b0;

        // R8: mid-run reset with the latch closed
        phase = "R8"; rst_n = 1'b0; go(2); rst_n = 1'b1; go(1);
        chk("R8", "col after second reset", int'(col_out), 0);
        go(2);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule